// File: doc/BRIEF.md
# Dual-mode adder/subtractor

This block is a purely combinational arithmetic unit for a datapath that must handle both plain binary and two's complement numbers without two separate adders. A 2-bit mode input chooses the operation (addition or subtraction) and how the operands are read (unsigned or signed). There is one carry chain, and the mode only changes what goes into it and which status flags are reported.

In subtraction the second operand is inverted and the carry input is added. A carry input of 1 therefore gives a plain difference, and a carry input of 0 takes away one more borrow, so wider subtractions can be chained. The carry output is the raw carry out of the top bit in every mode. A signed overflow flag reports whether the true signed result falls outside the representable range. The result bits do not depend on how the operands are read.

Top module: `addsub_unit`

## Requirements
- R1: In mode 00 (unsigned add), sum_o = (a_i + b_i + cin_i) mod 256, and cout_o = 1 exactly when a_i + b_i + cin_i >= 256.
- R2: In mode 01 (signed add), sum_o and cout_o are the same as in mode 00 for the same a_i, b_i and cin_i.
- R3: In mode 10 (unsigned subtract), sum_o = (a_i - b_i - 1 + cin_i) mod 256, so cin_i = 1 gives a_i - b_i.
- R4: In the subtract modes (10 and 11), cout_o = 1 exactly when a_i - b_i - 1 + cin_i >= 0, meaning no borrow. Mode 11 gives the same sum_o and cout_o as mode 10.
- R5: In modes 00 and 10, ovf_o is always 0.
- R6: In mode 01, ovf_o = 1 exactly when the signed value a_i + b_i + cin_i lies outside -128..127.
- R7: In mode 11, ovf_o = 1 exactly when the signed value a_i - b_i - 1 + cin_i lies outside -128..127.
- R8: The outputs follow any change of the inputs without a clock edge. The block holds no state.
- R9: The following corner cases give these results:
  - 0x7F + 0x01 in mode 01 with cin_i = 0 gives sum_o = 0x80 and ovf_o = 1.
  - 0x80 - 0x01 in mode 11 with cin_i = 1 gives sum_o = 0x7F and ovf_o = 1.
  - 0xFF + 0x01 in mode 00 with cin_i = 0 gives sum_o = 0x00 and cout_o = 1.
  - 0x00 - 0x01 in mode 10 with cin_i = 1 gives sum_o = 0xFF and cout_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand (the subtrahend in subtract modes) |
| cin_i | input | 1 | Carry in; in subtract modes, 1 means no incoming borrow |
| mode_i | input | 2 | Bit 1: subtract; bit 0: signed operands |
| sum_o | output | 8 | Result bits |
| cout_o | output | 1 | Carry out of the top bit |
| ovf_o | output | 1 | Signed overflow, valid in signed modes |

## Verification
The bench builds the unit with its default width of 8 bits. At this width every corner value can be reached directly: the extremes of the signed range, all-ones, zero, and the borrow across zero. The bench checks these with a strided sweep that covers all four modes and both carry-input values. Because the operands are this small, the reference model can work in plain integers and read the carry and overflow straight from the range of the exact result.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic [1:0] {
    MODE_ADD_U = 2'b00,
    MODE_ADD_S = 2'b01,
    MODE_SUB_U = 2'b10,
    MODE_SUB_S = 2'b11
  } addsub_mode_e;

  function automatic logic mode_is_sub(addsub_mode_e m);
    return (m == MODE_SUB_U) || (m == MODE_SUB_S);
  endfunction

  function automatic logic mode_is_signed(addsub_mode_e m);
    return (m == MODE_ADD_S) || (m == MODE_SUB_S);
  endfunction
endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] b_eff_o
);
  // conditional inversion; the +1 of the negation comes from cin
  assign b_eff_o = b_i ^ {WIDTH{sub_i}};
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH:0] carry;

  assign carry[0] = cin_i;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic prop;
    assign prop         = a_i[g] ^ b_i[g];
    assign sum_o[g]     = prop ^ carry[g];
    assign carry[g+1]   = (a_i[g] & b_i[g]) | (prop & carry[g]);
  end

  assign cout_o = carry[WIDTH];
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags (
  input  logic a_msb_i,
  input  logic b_msb_i,
  input  logic s_msb_i,
  input  logic signed_i,
  output logic ovf_o
);
  // same-sign operands producing opposite-sign result
  assign ovf_o = signed_i & ~(a_msb_i ^ b_msb_i) & (s_msb_i ^ a_msb_i);
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  addsub_mode_e     mode;
  logic             is_sub;
  logic             is_signed;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum_raw;

  assign mode      = addsub_mode_e'(mode_i);
  assign is_sub    = mode_is_sub(mode);
  assign is_signed = mode_is_signed(mode);

  addsub_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .b_i     (b_i),
    .sub_i   (is_sub),
    .b_eff_o (b_eff)
  );

  addsub_ripple #(.WIDTH(WIDTH)) u_chain (
    .a_i    (a_i),
    .b_i    (b_eff),
    .cin_i  (cin_i),
    .sum_o  (sum_raw),
    .cout_o (cout_o)
  );

  addsub_flags u_flags (
    .a_msb_i  (a_i[MSB]),
    .b_msb_i  (b_eff[MSB]),
    .s_msb_i  (sum_raw[MSB]),
    .signed_i (is_signed),
    .ovf_o    (ovf_o)
  );

  assign sum_o = sum_raw;
endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [1:0]       mode_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic             ovf_o
);
  localparam int SMAX = (1 << (WIDTH - 1)) - 1;
  localparam int SMIN = -(1 << (WIDTH - 1));

  int u_res;
  int s_res;
  logic known;

  always_comb begin
    known = !$isunknown({a_i, b_i, cin_i, mode_i, sum_o, cout_o, ovf_o});
    if (mode_i[1]) begin
      u_res = int'(a_i) - int'(b_i) - (cin_i ? 0 : 1);
      s_res = int'($signed(a_i)) - int'($signed(b_i)) - (cin_i ? 0 : 1);
    end else begin
      u_res = int'(a_i) + int'(b_i) + (cin_i ? 1 : 0);
      s_res = int'($signed(a_i)) + int'($signed(b_i)) + (cin_i ? 1 : 0);
    end
  end

  always_comb begin
    if (known) begin
      // R1 / R3: result bits are the exact value modulo 2^WIDTH
      assert_sum_R3: assert (sum_o == u_res[WIDTH-1:0]);
      // R1 / R4: carry out, no-borrow sense in subtraction
      assert_cout_R4: assert (cout_o == (mode_i[1] ? (u_res >= 0) : u_res[WIDTH]));
      assert_no_overflow_R5: assert (mode_i[0] || !ovf_o);
      // R6 / R7: flag equals signed range violation
      assert_overflow_R6: assert (!mode_i[0] || (ovf_o == ((s_res > SMAX) || (s_res < SMIN))));
    end
  end
endmodule

bind addsub_unit addsub_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i    (a_i),
  .b_i    (b_i),
  .cin_i  (cin_i),
  .mode_i (mode_i),
  .sum_o  (sum_o),
  .cout_o (cout_o),
  .ovf_o  (ovf_o)
);

// File: tb/tb_addsub_unit.sv
`timescale 1ns/1ps
module tb_addsub_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a_s = '0;
  logic [7:0] b_s = '0;
  logic       cin_s = 1'b0;
  logic [1:0] mode_s = 2'b00;
  logic [7:0] sum_w;
  logic       cout_w;
  logic       ovf_w;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  addsub_unit #(.WIDTH(8)) dut (
    .a_i    (a_s),
    .b_i    (b_s),
    .cin_i  (cin_s),
    .mode_i (mode_s),
    .sum_o  (sum_w),
    .cout_o (cout_w),
    .ovf_o  (ovf_w)
  );

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // drive one vector, sample at the falling edge, compare with integer model
  task automatic run_vec(input string tag, input logic [7:0] a, input logic [7:0] b,
                         input logic c, input logic [1:0] m);
    int ua, ub, sa, sb, ur, sr;
    logic [7:0] es;
    logic ec, eo;
    ua = int'(a);
    ub = int'(b);
    sa = int'($signed(a));
    sb = int'($signed(b));
    if (m[1]) begin
      ur = ua - ub - (c ? 0 : 1);
      sr = sa - sb - (c ? 0 : 1);
      ec = (ur >= 0);
    end else begin
      ur = ua + ub + (c ? 1 : 0);
      sr = sa + sb + (c ? 1 : 0);
      ec = ur[8];
    end
    es = ur[7:0];
    eo = m[0] && ((sr > 127) || (sr < -128));
    @(posedge clk);
    a_s = a; b_s = b; cin_s = c; mode_s = m;
    @(negedge clk);
    chk8({tag, " sum"}, sum_w, es);
    chk1({tag, " cout"}, cout_w, ec);
    chk1({tag, " ovf"}, ovf_w, eo);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    chk8("R1 idle sum", sum_w, 8'h00);
    chk1("R1 idle cout", cout_w, 1'b0);
    chk1("R5 idle ovf", ovf_w, 1'b0);
  endtask

  task automatic t_unsigned_add;
    run_vec("R1 add_u", 8'h12, 8'h34, 1'b0, 2'b00);
    run_vec("R1 add_u cin", 8'hF0, 8'h0F, 1'b1, 2'b00);
    run_vec("R5 add_u big", 8'hC8, 8'hC8, 1'b1, 2'b00);
  endtask

  task automatic t_signed_add;
    run_vec("R2 add_s", 8'hFF, 8'h01, 1'b0, 2'b01);
    run_vec("R6 add_s neg ovf", 8'h80, 8'hFF, 1'b0, 2'b01);
    run_vec("R6 add_s cin edge", 8'h7E, 8'h01, 1'b1, 2'b01);
  endtask

  task automatic t_unsigned_sub;
    run_vec("R3 sub_u", 8'h50, 8'h20, 1'b1, 2'b10);
    run_vec("R4 sub_u borrow in", 8'h20, 8'h20, 1'b0, 2'b10);
    run_vec("R4 sub_u equal", 8'h20, 8'h20, 1'b1, 2'b10);
  endtask

  task automatic t_signed_sub;
    run_vec("R7 sub_s", 8'h05, 8'h09, 1'b1, 2'b11);
    run_vec("R7 sub_s pos ovf", 8'h7F, 8'hFF, 1'b1, 2'b11);
    run_vec("R7 sub_s borrow ovf", 8'h80, 8'h00, 1'b0, 2'b11);
  endtask

  task automatic t_corners;
    run_vec("R9 7F+01", 8'h7F, 8'h01, 1'b0, 2'b01);
    chk8("R9 7F+01 value", sum_w, 8'h80);
    chk1("R9 7F+01 flag", ovf_w, 1'b1);
    run_vec("R9 80-01", 8'h80, 8'h01, 1'b1, 2'b11);
    chk8("R9 80-01 value", sum_w, 8'h7F);
    chk1("R9 80-01 flag", ovf_w, 1'b1);
    run_vec("R9 FF+01", 8'hFF, 8'h01, 1'b0, 2'b00);
    chk8("R9 FF+01 value", sum_w, 8'h00);
    chk1("R9 FF+01 carry", cout_w, 1'b1);
    run_vec("R9 00-01", 8'h00, 8'h01, 1'b1, 2'b10);
    chk8("R9 00-01 value", sum_w, 8'hFF);
    chk1("R9 00-01 carry", cout_w, 1'b0);
  endtask

  // inputs change between edges; outputs must follow with no edge in between
  task automatic t_no_clock;
    @(negedge clk);
    a_s = 8'h10; b_s = 8'h01; cin_s = 1'b0; mode_s = 2'b00;
    #0.5;
    chk8("R8 follow 1", sum_w, 8'h11);
    a_s = 8'h10; b_s = 8'h01; cin_s = 1'b1; mode_s = 2'b10;
    #0.5;
    chk8("R8 follow 2", sum_w, 8'h0F);
  endtask

  task automatic t_sweep;
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 2; c++) begin
        for (int a = 0; a < 256; a += 17) begin
          for (int b = 0; b < 256; b += 17) begin
            run_vec("R2 R4 sweep", 8'(a), 8'(b), 1'(c), 2'(m));
          end
          run_vec("R6 R7 sweep msb", 8'(a), 8'h80, 1'(c), 2'(m));
          run_vec("R6 R7 sweep max", 8'(a), 8'h7F, 1'(c), 2'(m));
        end
      end
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_unsigned_add();
    t_signed_add();
    t_unsigned_sub();
    t_signed_sub();
    t_corners();
    t_no_clock();
    t_sweep();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule